// File: doc/BRIEF.md
# Instruction Line Streaming Buffer

This block sits between a CPU instruction fetch port and a burst memory bus. It holds one 256-bit instruction line. When a fetch misses, the block issues a four-beat burst read. The beat that holds the requested half-word comes first, and the other beats follow in wrapping order. Each half-word is handed to the CPU as soon as its beat has landed, so the CPU does not wait for the whole line.

For cacheable code, the block works as a side buffer in front of the main instruction cache. A refill never writes the cache directly. The buffered line is copied into the cache array at the start of the next refill, but only when that line came from a cacheable address with bypass off.

For non-cacheable code, and for all code while bypass is on, the block acts as a one-line cache. A hit on a valid line costs no bus traffic. In bypass mode the cache lookup result is ignored and the cache array is never written. Bypass is on after reset.

The tag and data arrays of the main cache and the bus fabric are outside the block.

Top module: `iline_stream_buf`

## Requirements
- R1: A line is marked valid only after all four beats of its burst have been stored. A fetch to any half-word of a valid buffered line gets `fetchValid` in the same cycle and causes no bus request.
- R2: Each refill is one request handshake followed by exactly four data beats. `busReq` and `busAddr` stay unchanged until `busAck`.
- R3: `busAddr` carries the requested line address, with bits [4:3] set to the beat of the requested address and bits [2:0] zero. Beat k of the burst (k = 0..3) is stored at beat slot (critical + k) mod 4.
- R4: `fetchData` is the half-word at line byte offset `fetchAddr[4:0]`. Line half-word h sits at line bits [16h+15:16h], and beat b covers byte offsets 8b..8b+7. During a refill, a half-word whose beat has landed is served at once. A half-word whose beat has not landed stalls, and nothing is served while the request is pending.
- R5: A refill starts with a one-cycle `copyValid` when bypass is off and the buffer holds a valid line taken from a cacheable address. In that case `copyAddr` is the old line address and `copyData` is the whole old line. The bus request follows in the next cycle.
- R6: A line refilled from a non-cacheable address is never copied. A later non-cacheable fetch to that line hits without bus access.
- R7: While bypass is on, `cacheHit` is ignored and a cacheable fetch is served through the buffer. Lines refilled under bypass are never copied, and no copy happens while bypass is on.
- R8: Bypass is on after reset. A `bypassWr` pulse loads `bypassVal` into the bypass setting.
- R9: With bypass off, a cacheable fetch with `cacheHit` high is left to the cache: no `fetchValid` and no bus request.
- R10: A miss to a different line during a refill waits until all four beats of the current burst are in, and then starts its own refill.
- R11: After reset, `busReq`, `fetchValid` and `copyValid` are low and the buffer holds no valid line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bypassWr | input | 1 | Load strobe for the bypass setting |
| bypassVal | input | 1 | New bypass value (1 = bypass on) |
| fetchReq | input | 1 | Fetch request, held until served |
| fetchAddr | input | ADDR_W | Half-word aligned byte address of the fetch |
| fetchCacheable | input | 1 | Fetch address is cacheable |
| cacheHit | input | 1 | Main cache lookup hit for this fetch |
| fetchValid | output | 1 | Buffer returns `fetchData` this cycle |
| fetchData | output | 16 | Returned instruction half-word |
| busReq | output | 1 | Burst read request |
| busAddr | output | ADDR_W | Address of the critical beat |
| busAck | input | 1 | Bus accepts the request |
| busBeatValid | input | 1 | A data beat is present |
| busBeatData | input | 64 | Data beat |
| copyValid | output | 1 | Write the buffered line into the cache array |
| copyAddr | output | ADDR_W | Line address for the cache write |
| copyData | output | 256 | Line data for the cache write |

## Verification
The bench uses the default `ADDR_W` of 16 with the fixed 64-bit, four-beat line. That gives sixteen half-word slots per line, so the bench can start a refill at every possible critical half-word and then read back every half-word of each filled line. A slowed bus model spreads the beats apart, which exposes partial-line serving, stalling on missing beats and the wait for a different-line miss. Line copies are followed through a sequence that moves from bypass-filled lines to cacheable lines and then to non-cacheable lines.

// File: rtl/ilsb_pkg.sv
package ilsb_pkg;
  localparam int BEAT_W      = 64;
  localparam int LINE_BEATS  = 4;
  localparam int HW_W        = 16;
  localparam int LINE_W      = BEAT_W * LINE_BEATS;
  localparam int BEAT_IDX_W  = $clog2(LINE_BEATS);
  localparam int HW_PER_BEAT = BEAT_W / HW_W;
  localparam int HW_IDX_W    = $clog2(HW_PER_BEAT);
  localparam int HW_LSB      = $clog2(HW_W / 8);
  localparam int BEAT_LSB    = HW_LSB + HW_IDX_W;
  localparam int OFF_W       = BEAT_LSB + BEAT_IDX_W;

  // strobes from control to datapath
  typedef struct packed {
    logic                  startFill;
    logic                  beatWr;
    logic                  lastBeat;
    logic [BEAT_IDX_W-1:0] beatNum;
  } fillStrb_t;
endpackage

// File: rtl/ilsb_dpath.sv
module ilsb_dpath
  import ilsb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  fillStrb_t         strb,
  input  logic              bypassWr,
  input  logic              bypassVal,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchCacheable,
  input  logic              cacheHit,
  input  logic [BEAT_W-1:0] busBeatData,
  output logic              fetchValid,
  output logic [HW_W-1:0]   fetchData,
  output logic              missNow,
  output logic [ADDR_W-1:0] busAddr,
  output logic              copyValid,
  output logic [ADDR_W-1:0] copyAddr,
  output logic [LINE_W-1:0] copyData
);
  localparam int TAG_W = ADDR_W - OFF_W;

  logic [LINE_BEATS-1:0][BEAT_W-1:0] lineData;
  logic [LINE_BEATS-1:0]             beatHave;
  logic [TAG_W-1:0]                  lineTag;
  logic [BEAT_IDX_W-1:0]             critBeat;
  logic                              lineValid;
  logic                              lineCopyable;
  logic                              bypassOn;

  logic [TAG_W-1:0]      reqTag;
  logic [BEAT_IDX_W-1:0] reqBeat;
  logic [HW_IDX_W-1:0]   reqHw;
  logic [BEAT_IDX_W-1:0] wrSlot;
  logic [BEAT_W-1:0]     beatWord;
  logic                  active;
  logic                  bufHit;

  assign reqTag  = fetchAddr[ADDR_W-1:OFF_W];
  assign reqBeat = fetchAddr[OFF_W-1:BEAT_LSB];
  assign reqHw   = fetchAddr[BEAT_LSB-1:HW_LSB];
  assign wrSlot  = critBeat + strb.beatNum;

  // the cache serves cacheable hits unless bypass forces a miss
  assign active  = fetchReq && !(fetchCacheable && cacheHit && !bypassOn);
  assign bufHit  = active && (reqTag == lineTag) && (lineValid || beatHave[reqBeat]);
  assign missNow = active && !bufHit;

  always_comb beatWord = lineData[reqBeat];
  assign fetchValid = bufHit;
  assign fetchData  = beatWord[reqHw*HW_W +: HW_W];

  assign busAddr   = {lineTag, critBeat, {BEAT_LSB{1'b0}}};
  assign copyValid = strb.startFill && lineValid && lineCopyable && !bypassOn;
  assign copyAddr  = {lineTag, {OFF_W{1'b0}}};
  assign copyData  = lineData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineData     <= '0;
      beatHave     <= '0;
      lineTag      <= '0;
      critBeat     <= '0;
      lineValid    <= 1'b0;
      lineCopyable <= 1'b0;
      bypassOn     <= 1'b1;
    end else begin
      if (bypassWr) bypassOn <= bypassVal;
      if (strb.startFill) begin
        lineValid    <= 1'b0;
        beatHave     <= '0;
        lineTag      <= reqTag;
        critBeat     <= reqBeat;
        lineCopyable <= fetchCacheable && !bypassOn;
      end
      if (strb.beatWr) begin
        lineData[wrSlot] <= busBeatData;
        beatHave[wrSlot] <= 1'b1;
        if (strb.lastBeat) lineValid <= 1'b1;
      end
    end
  end

  // R1: a line turns valid only with all beats present
  assert_full_line_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineValid) |-> (&beatHave))
    else $error("line valid without all beats");

  // R3: burst address names the beat of the missing fetch
  assert_crit_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.startFill |=> busAddr[OFF_W-1:BEAT_LSB] == $past(fetchAddr[OFF_W-1:BEAT_LSB]))
    else $error("critical beat not requested first");

  // R8: bypass comes out of reset enabled
  assert_reset_bypass_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> bypassOn)
    else $error("bypass off after reset");
endmodule

// File: rtl/ilsb_ctrl.sv
module ilsb_ctrl
  import ilsb_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      missNow,
  input  logic      busAck,
  input  logic      busBeatValid,
  output fillStrb_t strb,
  output logic      busReq
);
  typedef enum logic [1:0] {S_IDLE, S_REQ, S_FILL} fillState_t;

  fillState_t            state;
  logic [BEAT_IDX_W-1:0] beatCnt;

  always_comb begin
    strb.startFill = (state == S_IDLE) && missNow;
    strb.beatWr    = (state == S_FILL) && busBeatValid;
    strb.lastBeat  = strb.beatWr && (beatCnt == BEAT_IDX_W'(LINE_BEATS - 1));
    strb.beatNum   = beatCnt;
  end
  assign busReq = (state == S_REQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      beatCnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (strb.startFill) state <= S_REQ;
        S_REQ: if (busAck) begin
          state   <= S_FILL;
          beatCnt <= '0;
        end
        S_FILL: if (strb.beatWr) begin
          beatCnt <= beatCnt + 1'b1;
          if (strb.lastBeat) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R2: the fourth beat closes the burst
  assert_four_beats_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.lastBeat |=> (state == S_IDLE))
    else $error("burst not closed after last beat");

  // R2: request held until accepted
  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> busReq)
    else $error("request dropped before ack");
endmodule

// File: rtl/iline_stream_buf.sv
module iline_stream_buf
  import ilsb_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bypassWr,
  input  logic              bypassVal,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic              fetchCacheable,
  input  logic              cacheHit,
  output logic              fetchValid,
  output logic [HW_W-1:0]   fetchData,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  input  logic              busAck,
  input  logic              busBeatValid,
  input  logic [BEAT_W-1:0] busBeatData,
  output logic              copyValid,
  output logic [ADDR_W-1:0] copyAddr,
  output logic [LINE_W-1:0] copyData
);
  fillStrb_t strb;
  logic      missNow;

  ilsb_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .missNow(missNow), .busAck(busAck),
    .busBeatValid(busBeatValid), .strb(strb), .busReq(busReq)
  );

  ilsb_dpath #(.ADDR_W(ADDR_W)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .bypassWr(bypassWr), .bypassVal(bypassVal),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchCacheable(fetchCacheable),
    .cacheHit(cacheHit), .busBeatData(busBeatData), .fetchValid(fetchValid),
    .fetchData(fetchData), .missNow(missNow), .busAddr(busAddr),
    .copyValid(copyValid), .copyAddr(copyAddr), .copyData(copyData)
  );

  // R2: address stable while the request waits
  assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    busReq && !busAck |=> $stable(busAddr))
    else $error("bus address changed before ack");

  // R5: a line copy is followed by the refill request
  assert_copy_then_req_R5: assert property (@(posedge clk) disable iff (!rstN)
    copyValid |=> busReq)
    else $error("copy without refill");

  // R4: nothing served while the burst is still being requested
  assert_no_early_data_R4: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> !fetchValid)
    else $error("data served before any beat");
endmodule

// File: tb/sim_iline_stream_buf.sv
module sim_iline_stream_buf;
  import ilsb_pkg::*;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bypassWr = 1'b0, bypassVal = 1'b0;
  logic fetchReq = 1'b0, fetchCacheable = 1'b0, cacheHit = 1'b0;
  logic [AW-1:0] fetchAddr = '0;
  logic fetchValid, busReq, busAck, busBeatValid, copyValid;
  logic [15:0] fetchData;
  logic [AW-1:0] busAddr, copyAddr;
  logic [63:0] busBeatData;
  logic [255:0] copyData;

  always #4 clk = ~clk;

  iline_stream_buf #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .bypassWr(bypassWr), .bypassVal(bypassVal),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchCacheable(fetchCacheable),
    .cacheHit(cacheHit), .fetchValid(fetchValid), .fetchData(fetchData),
    .busReq(busReq), .busAddr(busAddr), .busAck(busAck), .busBeatValid(busBeatValid),
    .busBeatData(busBeatData), .copyValid(copyValid), .copyAddr(copyAddr), .copyData(copyData)
  );

  int checks = 0, errors = 0;
  int beatGap = 0;
  int reqCount = 0, beatCount = 0, beatsAtLastReq = 0;
  int copyCount = 0;
  logic [AW-1:0] lastBusAddr = '0, lastCopyAddr = '0;
  logic [255:0] lastCopyData = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] hwVal(input logic [15:0] a);
    logic [15:0] h;
    h = {1'b0, a[15:1]};
    return (h * 16'd73) ^ 16'h3C5A;
  endfunction

  function automatic logic [63:0] beatVal(input logic [15:0] a);
    logic [63:0] v;
    for (int h = 0; h < 4; h++) v[16*h +: 16] = hwVal(a + 16'(2*h));
    return v;
  endfunction

  function automatic logic [255:0] lineVal(input logic [15:0] base);
    logic [255:0] v;
    for (int b = 0; b < 4; b++) v[64*b +: 64] = beatVal(base + 16'(8*b));
    return v;
  endfunction

  // bus model: ack one cycle late, then four wrapping beats with gaps
  initial begin
    busAck = 1'b0; busBeatValid = 1'b0; busBeatData = '0;
    forever begin
      @(negedge clk);
      if (rstN && busReq) begin
        @(negedge clk);
        lastBusAddr = busAddr;
        beatsAtLastReq = beatCount;
        reqCount++;
        busAck = 1'b1;
        @(negedge clk);
        busAck = 1'b0;
        for (int k = 0; k < 4; k++) begin
          logic [1:0] slot;
          repeat (beatGap) @(negedge clk);
          slot = lastBusAddr[4:3] + 2'(k);
          busBeatValid = 1'b1;
          busBeatData = beatVal({lastBusAddr[15:5], slot, 3'b000});
          @(negedge clk);
          busBeatValid = 1'b0;
          beatCount++;
        end
      end
    end
  end

  task automatic fetch(input logic [15:0] a, input bit cach, input bit hit, input int maxWait,
                       output logic [15:0] data, output int waits, output bit got, output bit sawBus);
    @(negedge clk);
    fetchReq = 1'b1; fetchAddr = a; fetchCacheable = cach; cacheHit = hit;
    waits = 0; got = 0; sawBus = 0; data = '0;
    for (int i = 0; i < maxWait; i++) begin
      #2;
      if (busReq) sawBus = 1;
      if (copyValid) begin
        copyCount++; lastCopyAddr = copyAddr; lastCopyData = copyData;
      end
      if (fetchValid) begin
        data = fetchData; got = 1;
        break;
      end
      @(negedge clk);
      waits++;
    end
  endtask

  task automatic waitFill();
    while ((beatCount - beatsAtLastReq) < 4 || busReq) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic setBypass(input bit v);
    @(negedge clk);
    bypassWr = 1'b1; bypassVal = v;
    @(negedge clk);
    bypassWr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d, base, a;
    int w, r0, c0, b0;
    bit got, sb;

    repeat (4) @(negedge clk);
    #2;
    check(busReq == 0, "R11", "busReq in reset", busReq, 0);
    check(copyValid == 0, "R11", "copyValid in reset", copyValid, 0);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    check(busReq == 0 && fetchValid == 0, "R11", "idle after reset", {busReq, fetchValid}, 0);

    // bypass from reset: every critical start and every half-word readback
    beatGap = 0;
    for (int s = 0; s < 16; s++) begin
      base = 16'h1000 + 16'(s * 32);
      a = base + 16'(s * 2);
      r0 = reqCount;
      fetch(a, 1, 1, 60, d, w, got, sb);
      check(got && d == hwVal(a), "R4", "streamed half-word", d, hwVal(a));
      check(reqCount == r0 + 1, (s == 0) ? "R8" : "R7", "bypass forces refill", reqCount, r0 + 1);
      check(lastBusAddr == {base[15:5], 2'(s / 4), 3'b000}, "R3", "critical beat address",
            lastBusAddr, {base[15:5], 2'(s / 4), 3'b000});
      waitFill();
      r0 = reqCount;
      for (int j = 0; j < 16; j++) begin
        fetch(base + 16'(2*j), 1, 1, 60, d, w, got, sb);
        check(got && w == 0 && d == hwVal(base + 16'(2*j)), "R1", "valid line hit",
              d, hwVal(base + 16'(2*j)));
      end
      check(reqCount == r0, "R1", "no bus on hits", reqCount, r0);
    end
    check(copyCount == 0, "R7", "no copy under bypass", copyCount, 0);

    // streaming with a slow bus
    beatGap = 5;
    r0 = reqCount;
    fetch(16'h300A, 0, 0, 80, d, w, got, sb);
    check(got && d == hwVal(16'h300A), "R4", "critical half-word", d, hwVal(16'h300A));
    fetch(16'h3008, 0, 0, 80, d, w, got, sb);
    check(got && w == 0 && d == hwVal(16'h3008), "R4", "landed beat served at once", w, 0);
    fetch(16'h3002, 0, 0, 80, d, w, got, sb);
    check(got && w >= 10 && d == hwVal(16'h3002), "R4", "missing beat stalls", w, 10);
    check(reqCount == r0 + 1, "R2", "one burst per line", reqCount, r0 + 1);
    waitFill();

    r0 = reqCount;
    fetch(16'h3104, 0, 0, 80, d, w, got, sb);
    b0 = beatsAtLastReq;
    fetch(16'h3200, 0, 0, 120, d, w, got, sb);
    check(got && d == hwVal(16'h3200), "R10", "queued miss data", d, hwVal(16'h3200));
    check(reqCount == r0 + 2 && beatsAtLastReq == b0 + 4, "R10", "waited for full burst",
          beatsAtLastReq, b0 + 4);
    waitFill();

    // cache interaction with bypass off
    beatGap = 1;
    setBypass(0);
    r0 = reqCount;
    fetch(16'h5000, 1, 1, 6, d, w, got, sb);
    check(!got && !sb && reqCount == r0, "R9", "cache hit left alone", {got, sb}, 0);
    check(!got, "R8", "bypass cleared by write", got, 0);
    fetchReq = 1'b0;

    c0 = copyCount;
    fetch(16'h4006, 1, 0, 60, d, w, got, sb);
    check(got && d == hwVal(16'h4006), "R4", "cacheable miss data", d, hwVal(16'h4006));
    check(copyCount == c0, "R7", "line filled under bypass not copied", copyCount, c0);
    waitFill();

    fetch(16'h4410, 1, 0, 60, d, w, got, sb);
    check(copyCount == c0 + 1, "R5", "copy on next miss", copyCount, c0 + 1);
    check(lastCopyAddr == 16'h4000, "R5", "copy address", lastCopyAddr, 16'h4000);
    check(lastCopyData == lineVal(16'h4000), "R5", "copy data", lastCopyData, lineVal(16'h4000));
    waitFill();

    fetch(16'h6002, 0, 0, 60, d, w, got, sb);
    check(copyCount == c0 + 2 && lastCopyAddr == 16'h4400, "R5", "copy before non-cacheable refill",
          lastCopyAddr, 16'h4400);
    check(lastCopyData == lineVal(16'h4400), "R5", "second copy data", lastCopyData, lineVal(16'h4400));
    waitFill();
    r0 = reqCount;
    fetch(16'h601E, 0, 0, 60, d, w, got, sb);
    check(got && w == 0 && reqCount == r0 && d == hwVal(16'h601E), "R6", "non-cacheable hit",
          d, hwVal(16'h601E));

    fetch(16'h4800, 1, 0, 60, d, w, got, sb);
    check(copyCount == c0 + 2, "R6", "non-cacheable line not copied", copyCount, c0 + 2);
    waitFill();

    setBypass(1);
    fetch(16'h4C00, 1, 0, 60, d, w, got, sb);
    check(copyCount == c0 + 2, "R7", "no copy with bypass on", copyCount, c0 + 2);
    waitFill();
    r0 = reqCount;
    fetch(16'h4C08, 1, 1, 60, d, w, got, sb);
    check(got && w == 0 && reqCount == r0 && d == hwVal(16'h4C08), "R7", "bypass ignores cacheHit",
          d, hwVal(16'h4C08));
    fetchReq = 1'b0;

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule